// File: doc/BRIEF.md
# Key-Locked GPIO Pad Configuration Bank

This block is the register and pad-control logic for one bank of general-purpose pins. Each pin has its own configuration word. The word selects the pin function, turns input sampling on, can force reads to zero, selects which edges an interrupt controller watches, and picks one of four IO modes. The bank also holds an output-value vector and an output-enable vector. Each vector can be written whole, or changed bit by bit through set and clear aliases.

Software reaches everything through a single-cycle word bus: a write strobe, a word address and write data, with read data returned combinationally. The configuration words are guarded by a key register. While the key does not hold the unlock value, writes to any configuration word are dropped with no side effect. The other registers can always be written. From the IO mode, output value and output enable, the block computes the level and drive enable for each pad. It also returns input data masked per pin. The input-enable and edge-mode fields go straight out to a neighbouring interrupt controller.

Word address map for the default 32 pins: 0..31 configuration words, 32 key, 33 input read, 34 output value, 35 output set, 36 output clear, 37 output-enable, 38 output-enable set, 39 output-enable clear. Other addresses are unmapped.

Top module: `pad_cfg_bank`

## Requirements
- R1: After reset, every configuration word reads 0x3 (function select = GPIO), the key reads 0, the output and output-enable vectors read 0, and no pad is driven.
- R2: A write to a configuration word is discarded unless the key register holds exactly 0x73 in all 32 bits; for example 0x173 leaves the bank locked.
- R3: An accepted configuration write stores wdata[9:0]: [3:0] function select, [4] input enable, [5] read-zero, [7:6] edge mode, [9:8] IO mode. Bits [31:10] read as 0.
- R4: The key register is a 32-bit read/write register that is never locked.
- R5: A write to the output-value word replaces all output bits. The output-value, output-set and output-clear addresses all read back the current output bits.
- R6: Writing to the output-set word sets every bit where wdata is 1 and leaves the others unchanged.
- R7: Writing to the output-clear word clears every bit where wdata is 1 and leaves the others unchanged.
- R8: The output-enable vector has write, set and clear addresses with the same rules as R5 to R7, and all three read back the current enable bits.
- R9: For each pin, the pad is driven (pad_drive_en) in IO mode 1 (push-pull) always, in mode 3 (tristate push-pull) when the pin's output-enable bit is 1, and never in mode 0 (disabled) or mode 2 (open-drain). pad_level = pad_drive_en AND output bit.
- R10: The input read word returns pad_in for pins whose input enable is 1 and whose read-zero bit is 0, and 0 for all other pins.
- R11: pin_in_en[i] equals configuration bit 4 of pin i, and pin_edge_mode[2i+1:2i] equals bits [7:6] of pin i.
- R12: Reads of unmapped addresses return 0.
- R13: A write changes its register on the clock edge that samples it. The read data seen before that edge still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| pad_in | input | NUM_PINS | Current pad levels |
| pad_level | output | NUM_PINS | Level driven on each pad |
| pad_drive_en | output | NUM_PINS | Pad driver enable per pin |
| pin_in_en | output | NUM_PINS | Per-pin input enable for the interrupt controller |
| pin_edge_mode | output | 2*NUM_PINS | Per-pin edge mode, two bits per pin |

## Verification
Every register result is due one edge after the write strobe is sampled. Read data, pad level, drive enable, input read and the exported fields are combinational from that register state and from pad_in. The bench therefore drives the strobe at the falling edge and lets exactly one rising edge capture it. It samples at the next falling phase, and for R13 it also samples just before the capturing edge. The drive sweep gives each pin every IO mode and pairs it with several value and enable patterns. The expected vectors are computed bit by bit from the mode rules.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
  localparam int CFG_W = 10;

  typedef enum logic [1:0] {
    IOM_OFF       = 2'd0,
    IOM_PUSHPULL  = 2'd1,
    IOM_OPENDRAIN = 2'd2,
    IOM_TRISTATE  = 2'd3
  } iomode_e;

  // Field positions inside a configuration word
  localparam int FLD_FSEL_LO = 0;
  localparam int FLD_INEN    = 4;
  localparam int FLD_RDZ     = 5;
  localparam int FLD_EDGE_LO = 6;
  localparam int FLD_MODE_LO = 8;

  localparam logic [CFG_W-1:0] CFG_RESET = 10'h003;

  // Offsets of the shared words, placed after the per-pin words
  localparam int OFS_KEY     = 0;
  localparam int OFS_IN      = 1;
  localparam int OFS_OUT_WR  = 2;
  localparam int OFS_OUT_SET = 3;
  localparam int OFS_OUT_CLR = 4;
  localparam int OFS_OE_WR   = 5;
  localparam int OFS_OE_SET  = 6;
  localparam int OFS_OE_CLR  = 7;
  localparam int NUM_SHARED  = 8;
endpackage

// File: rtl/pad_key_lock.sv
module pad_key_lock #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_VALUE = 'h73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] key_q,
  output logic              unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     key_q <= '0;
    else if (wr_en) key_q <= wdata;
  end

  assign unlocked = (key_q == KEY_VALUE);
endmodule

// File: rtl/pad_cfg_file.sv
module pad_cfg_file
  import pad_cfg_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [CFG_W-1:0]          wdata,
  output logic [NUM_PINS*CFG_W-1:0] cfg_flat
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CFG_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   word_q <= CFG_RESET;
      else if (wr_en && wr_idx == IDX_W'(p))        word_q <= wdata;
    end
    assign cfg_flat[p*CFG_W +: CFG_W] = word_q;
  end
endmodule

// File: rtl/pad_alias_reg.sv
module pad_alias_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_en)  q <= wdata;
    else if (set_en) q <= q | wdata;
    else if (clr_en) q <= q & ~wdata;
  end
endmodule

// File: rtl/pad_drive.sv
module pad_drive
  import pad_cfg_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [2*NUM_PINS-1:0] mode_flat,
  input  logic [NUM_PINS-1:0]   in_en,
  input  logic [NUM_PINS-1:0]   rd_zero,
  input  logic [NUM_PINS-1:0]   out_val,
  input  logic [NUM_PINS-1:0]   out_en,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   drive_en,
  output logic [NUM_PINS-1:0]   level,
  output logic [NUM_PINS-1:0]   in_data
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    iomode_e mode;
    assign mode = iomode_e'(mode_flat[2*p +: 2]);
    always_comb begin
      unique case (mode)
        IOM_PUSHPULL: drive_en[p] = 1'b1;
        IOM_TRISTATE: drive_en[p] = out_en[p];
        default:      drive_en[p] = 1'b0;
      endcase
    end
    assign level[p]   = drive_en[p] & out_val[p];
    assign in_data[p] = in_en[p] & ~rd_zero[p] & pad_in[p];
  end
endmodule

// File: rtl/pad_cfg_bank.sv
module pad_cfg_bank
  import pad_cfg_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_VALUE = 'h73,
  parameter int ADDR_W = $clog2(NUM_PINS + NUM_SHARED)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_level,
  output logic [NUM_PINS-1:0]   pad_drive_en,
  output logic [NUM_PINS-1:0]   pin_in_en,
  output logic [2*NUM_PINS-1:0] pin_edge_mode
);
  localparam int IDX_W = $clog2(NUM_PINS);
  localparam logic [ADDR_W-1:0] A_KEY     = ADDR_W'(NUM_PINS + OFS_KEY);
  localparam logic [ADDR_W-1:0] A_IN      = ADDR_W'(NUM_PINS + OFS_IN);
  localparam logic [ADDR_W-1:0] A_OUT_WR  = ADDR_W'(NUM_PINS + OFS_OUT_WR);
  localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(NUM_PINS + OFS_OUT_SET);
  localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(NUM_PINS + OFS_OUT_CLR);
  localparam logic [ADDR_W-1:0] A_OE_WR   = ADDR_W'(NUM_PINS + OFS_OE_WR);
  localparam logic [ADDR_W-1:0] A_OE_SET  = ADDR_W'(NUM_PINS + OFS_OE_SET);
  localparam logic [ADDR_W-1:0] A_OE_CLR  = ADDR_W'(NUM_PINS + OFS_OE_CLR);

  logic                      is_cfg;
  logic                      unlocked;
  logic [DATA_W-1:0]         key_q;
  logic [NUM_PINS*CFG_W-1:0] cfg_flat;
  logic [NUM_PINS-1:0]       out_q, oe_q, in_data, rd_zero;
  logic [2*NUM_PINS-1:0]     mode_flat;

  assign is_cfg = (bus_addr < ADDR_W'(NUM_PINS));

  pad_key_lock #(.DATA_W(DATA_W), .KEY_VALUE(KEY_VALUE)) u_key (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_we && bus_addr == A_KEY),
    .wdata(bus_wdata), .key_q(key_q), .unlocked(unlocked)
  );

  pad_cfg_file #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_we && is_cfg && unlocked),
    .wr_idx(bus_addr[IDX_W-1:0]),
    .wdata(bus_wdata[CFG_W-1:0]),
    .cfg_flat(cfg_flat)
  );

  pad_alias_reg #(.W(NUM_PINS)) u_out (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_we && bus_addr == A_OUT_WR),
    .set_en(bus_we && bus_addr == A_OUT_SET),
    .clr_en(bus_we && bus_addr == A_OUT_CLR),
    .wdata(bus_wdata[NUM_PINS-1:0]), .q(out_q)
  );

  pad_alias_reg #(.W(NUM_PINS)) u_oe (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_we && bus_addr == A_OE_WR),
    .set_en(bus_we && bus_addr == A_OE_SET),
    .clr_en(bus_we && bus_addr == A_OE_CLR),
    .wdata(bus_wdata[NUM_PINS-1:0]), .q(oe_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_fld
    assign pin_in_en[p]           = cfg_flat[p*CFG_W + FLD_INEN];
    assign rd_zero[p]             = cfg_flat[p*CFG_W + FLD_RDZ];
    assign pin_edge_mode[2*p +: 2] = cfg_flat[p*CFG_W + FLD_EDGE_LO +: 2];
    assign mode_flat[2*p +: 2]     = cfg_flat[p*CFG_W + FLD_MODE_LO +: 2];
  end

  pad_drive #(.NUM_PINS(NUM_PINS)) u_drive (
    .mode_flat(mode_flat), .in_en(pin_in_en), .rd_zero(rd_zero),
    .out_val(out_q), .out_en(oe_q), .pad_in(pad_in),
    .drive_en(pad_drive_en), .level(pad_level), .in_data(in_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (is_cfg) begin
      bus_rdata = DATA_W'(cfg_flat[bus_addr[IDX_W-1:0]*CFG_W +: CFG_W]);
    end else begin
      case (bus_addr)
        A_KEY:                          bus_rdata = key_q;
        A_IN:                           bus_rdata = DATA_W'(in_data);
        A_OUT_WR, A_OUT_SET, A_OUT_CLR: bus_rdata = DATA_W'(out_q);
        A_OE_WR, A_OE_SET, A_OE_CLR:    bus_rdata = DATA_W'(oe_q);
        default:                        bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pad_cfg_chk.sv
module pad_cfg_chk
  import pad_cfg_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_VALUE = 'h73,
  parameter int ADDR_W = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_we,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [DATA_W-1:0]         key_q,
  input logic [NUM_PINS*CFG_W-1:0] cfg_flat,
  input logic [NUM_PINS-1:0]       out_q,
  input logic [NUM_PINS-1:0]       pin_in_en,
  input logic [NUM_PINS-1:0]       pad_level
);
  localparam logic [ADDR_W-1:0] A_IN      = ADDR_W'(NUM_PINS + OFS_IN);
  localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(NUM_PINS + OFS_OUT_SET);
  localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(NUM_PINS + OFS_OUT_CLR);

  // R2
  locked_cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr < ADDR_W'(NUM_PINS) && key_q != KEY_VALUE) |=> $stable(cfg_flat));

  // R6
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OUT_SET) |=>
      ((out_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

  // R7
  out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OUT_CLR) |=> ((out_q & $past(bus_wdata[NUM_PINS-1:0])) == '0));

  // R9
  level_needs_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_level & ~out_q) == '0);

  // R10
  input_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_IN) |-> ((bus_rdata[NUM_PINS-1:0] & ~pin_in_en) == '0));
endmodule

bind pad_cfg_bank pad_cfg_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .KEY_VALUE(KEY_VALUE), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_q(key_q),
  .cfg_flat(cfg_flat), .out_q(out_q), .pin_in_en(pin_in_en), .pad_level(pad_level)
);

// File: tb/tb_pad_cfg_bank.sv
module tb_pad_cfg_bank;
  localparam int NP = 32;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_KEY = 6'd32, A_IN = 6'd33, A_OW = 6'd34, A_OS = 6'd35,
                            A_OC = 6'd36, A_EW = 6'd37, A_ES = 6'd38, A_EC = 6'd39;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] pad_in = '0, level, drv, ien;
  logic [2*NP-1:0] edge_m;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pad_cfg_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pad_in(pad_in), .pad_level(level), .pad_drive_en(drv),
    .pin_in_en(ien), .pin_edge_mode(edge_m)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, captured at the next rising edge.
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [31:0] cfg_of(int p);
    int mode = p % 4, edg = (p / 4) % 4;
    bit ie = (p % 3) != 0, rz = (p % 5) == 0;
    return 32'((mode << 8) | (edg << 6) | (int'(rz) << 5) | (int'(ie) << 4) | (p % 16));
  endfunction

  initial begin
    logic [31:0] d, ov, ev, exp_en, exp_in;
    logic [31:0] pats [6] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0F0F_3C3C,
                              32'h1234_5678, 32'h8000_0001};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int p = 0; p < NP; p++) begin
      rd(AW'(p), d); check("R1 cfg reset", d, 32'h3);
    end
    rd(A_KEY, d); check("R1 key reset", d, 0);
    rd(A_OW, d);  check("R1 out reset", d, 0);
    rd(A_EW, d);  check("R1 oe reset", d, 0);
    check("R1 level reset", {level, drv}, 0);

    // R2 locked writes dropped
    wr(AW'(5), 32'h2AB); rd(AW'(5), d); check("R2 locked write", d, 32'h3);
    wr(A_KEY, 32'h173);  rd(AW'(5), d); check("R4 key readback", d, 32'h3);
    rd(A_KEY, d); check("R4 key value", d, 32'h173);
    wr(AW'(5), 32'h2AB); rd(AW'(5), d); check("R2 near-key write", d, 32'h3);
    // R3 unlock and field width
    wr(A_KEY, 32'h73);
    wr(AW'(7), 32'hFFFF_FFFF); rd(AW'(7), d); check("R3 upper bits zero", d, 32'h3FF);
    // R13 old value until the capturing edge
    @(negedge clk); we = 1'b1; addr = AW'(7); wdata = 32'h155;
    #1 check("R13 before edge", rdata, 32'h3FF);
    @(posedge clk); #1 we = 1'b0;
    check("R13 after edge", rdata, 32'h155);
    wr(A_KEY, 32'h0); wr(AW'(7), 32'h0); rd(AW'(7), d); check("R2 relock", d, 32'h155);
    wr(A_KEY, 32'h73);

    // R12 unmapped
    for (int a = 40; a < 64; a++) begin
      rd(AW'(a), d); check("R12 unmapped", d, 0);
    end

    // R5 R6 R7 output vector
    wr(A_OW, 32'hCAFE_F00D); rd(A_OW, d); check("R5 out write", d, 32'hCAFE_F00D);
    wr(A_OS, 32'h0000_00F0); rd(A_OS, d); check("R6 out set", d, 32'hCAFE_F0FD);
    wr(A_OC, 32'hC000_000D); rd(A_OC, d); check("R7 out clear", d, 32'h0AFE_F0F0);
    wr(A_OS, 32'h0); rd(A_OW, d); check("R6 zero set", d, 32'h0AFE_F0F0);
    wr(A_OC, 32'h0); rd(A_OW, d); check("R7 zero clear", d, 32'h0AFE_F0F0);
    // R8 enable vector
    wr(A_EW, 32'h1111_0000); rd(A_EW, d); check("R8 oe write", d, 32'h1111_0000);
    wr(A_ES, 32'h0000_0022); rd(A_ES, d); check("R8 oe set", d, 32'h1111_0022);
    wr(A_EC, 32'h0100_0002); rd(A_EC, d); check("R8 oe clear", d, 32'h1011_0020);

    // Configure every pin; R3 readback and R11 exports
    for (int p = 0; p < NP; p++) wr(AW'(p), cfg_of(p));
    for (int p = 0; p < NP; p++) begin
      rd(AW'(p), d); check("R3 cfg readback", d, cfg_of(p));
      check("R11 in_en export", ien[p], cfg_of(p) >> 4 & 1);
      check("R11 edge export", edge_m[2*p +: 2], cfg_of(p) >> 6 & 3);
    end

    // R9 sweep: every mode against value/enable patterns
    foreach (pats[i]) foreach (pats[j]) begin
      ov = pats[i]; ev = pats[j] ^ 32'h3333_3333;
      wr(A_OW, ov); wr(A_EW, ev);
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        case (p % 4)
          1: exp_en[p] = 1'b1;
          3: exp_en[p] = ev[p];
          default: exp_en[p] = 1'b0;
        endcase
      end
      check("R9 drive enable", drv, exp_en);
      check("R9 pad level", level, exp_en & ov);
    end

    // R10 input gating
    foreach (pats[i]) begin
      @(negedge clk); pad_in = pats[i] ^ 32'h00FF_FF00;
      for (int p = 0; p < NP; p++)
        exp_in[p] = pad_in[p] & ((p % 3) != 0) & ((p % 5) != 0);
      rd(A_IN, d); check("R10 input read", d, exp_in);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule